// File: doc/BRIEF.md
# Asynchronous Host Write Port

This block is the slave end of an asynchronous host bus. The host drives its pins with no clock. The port samples chip select, a 4-bit chip identifier, an address, a data bus of up to eight byte lanes, per-lane byte strobes, a separate read strobe and a read/write line, all with its own local clock. When a strobe falls while chip select is active, the port compares the identifier with its programmed value. If the two match, the port drives an active-low acknowledge, captures the data bus together with a byte mask, and when the strobes rise it issues a one-cycle internal write request.

Two strobe schemes are supported. In the dual scheme, writes use the byte strobes and reads use the read strobe. In the single scheme, the byte strobes carry both kinds of access and the read/write line tells them apart. A 32-bit mode uses only the lower four lanes. The end of each access follows a two-field policy. The acknowledge line is either released at once, for a board with a pull-down, or driven high for a programmed number of local cycles and then released, for a board with a pull-up. The line is modelled as a value plus an output enable.

Top module: `hsp_async_port`

## Requirements
- R1: While reset is high, and on the first cycle after it, host_ack_oe and wr_valid are 0.
- R2: The identifier is compared only on the first falling strobe edge seen with chip select low. Changes on host_id after that edge have no effect until chip select rises.
- R3: If the compared identifier differs from cfg_chip_id, the port never enables acknowledge and issues no write until chip select rises.
- R4: On a match, host_ack_oe goes to 1 with host_ack_n at 0 on the fifth local clock edge after the host lowers its strobe: two synchronizer stages, the edge detection, and then two cycles after the match.
- R5: One cycle after acknowledge is asserted, the port captures address, data and mask. Mask bit i is 1 when byte strobe i is low. Lane i is data bits 8i+7 down to 8i.
- R6: A write access produces wr_valid high for exactly one cycle, on the third local edge after the host raises its strobes, carrying the captured address, data and mask.
- R7: With cfg_drv_en at 1 and cfg_drv_time N nonzero, acknowledge is driven high for exactly N local cycles after the end of the access, starting on that same third edge, and then released.
- R8: With cfg_drv_en at 0, or cfg_drv_time at 00, acknowledge is released on that third edge with no high drive.
- R9: A read (the read strobe in the dual scheme, or byte strobes with host_rnw at 1 in the single scheme) is acknowledged like a write but produces no write request.
- R10: With cfg_wide at 0, strobes 7..4 are ignored, and wr_mask[7:4] and wr_data[63:32] are 0.
- R11: When chip select is released, the port returns to idle. If the strobes rise in the same cycle, the write and the end-of-access policy still take place. If chip select is released before the strobes rise, acknowledge is dropped and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chip_id | input | 4 | Programmed identifier |
| cfg_drv_en | input | 1 | End-of-access drive enable |
| cfg_drv_time | input | 2 | High drive length in local cycles |
| cfg_single | input | 1 | 1 = single strobe scheme, 0 = dual |
| cfg_wide | input | 1 | 1 = eight lanes, 0 = four lanes |
| host_cs_n | input | 1 | Chip select, active low |
| host_id | input | 4 | Host identifier |
| host_addr | input | ADDR_W | Host address |
| host_data | input | 64 | Host data bus |
| host_bstb_n | input | 8 | Byte strobes, active low |
| host_rstb_n | input | 1 | Read strobe (dual scheme), active low |
| host_rnw | input | 1 | Read/write line (single scheme), 1 = read |
| host_ack_n | output | 1 | Acknowledge value |
| host_ack_oe | output | 1 | Acknowledge output enable |
| wr_valid | output | 1 | Write request pulse |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 64 | Write data |
| wr_mask | output | 8 | Write byte mask |

## Verification
The end of an access and the release of chip select can land in the same local cycle. The port must then issue the write and apply the drive policy rather than fall straight back to idle. The bench provokes this by raising the strobes and chip select on the same falling clock edge. It judges the outcome by the write pulse and its payload, the count of high-drive cycles, and a quiet port afterwards. The opposite ordering, where chip select is released while the strobes are still low, is also provoked, and there the bench expects no write at all.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int HSP_LANES = 8;
    localparam int HSP_IDW   = 4;
    localparam int HSP_TW    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_SETUP,
        ST_ACK,
        ST_DRIVE,
        ST_WAITCS,
        ST_IGNORE
    } hsp_state_e;

    typedef struct packed {
        logic              drv_en;
        logic [HSP_TW-1:0] drv_time;
    } hsp_endcfg_t;

    function automatic logic hsp_drive_after(hsp_endcfg_t c);
        return c.drv_en && (c.drv_time != '0);
    endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hsp_strobe_edge.sv
module hsp_strobe_edge #(
    parameter int LANES = hsp_pkg::HSP_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             single,
    input  logic             wide,
    input  logic [LANES-1:0] bstb_n_s,
    input  logic             rstb_n_s,
    input  logic             rnw_s,
    output logic [LANES-1:0] lanes_act,
    output logic             is_write,
    output logic             fall,
    output logic             rise
);
    logic [LANES-1:0] lane_en;
    logic             any_act;
    logic             any_prev;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < LANES / 2) begin : g_low
            assign lane_en[i] = 1'b1;
        end else begin : g_high
            assign lane_en[i] = wide;
        end
    end

    always_comb begin
        lanes_act = ~bstb_n_s & lane_en;
        if (single) begin
            any_act  = |lanes_act;
            is_write = ~rnw_s;
        end else begin
            any_act  = (|lanes_act) | ~rstb_n_s;
            is_write = |lanes_act;
        end
        fall = any_act & ~any_prev;
        rise = ~any_act & any_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) any_prev <= 1'b0;
        else     any_prev <= any_act;
    end
endmodule

// File: rtl/hsp_capture.sv
module hsp_capture #(
    parameter int ADDR_W = 16,
    parameter int LANES  = hsp_pkg::HSP_LANES,
    localparam int DW    = LANES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              wide,
    input  logic [LANES-1:0]  lanes_act,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DW-1:0]     data_s,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DW-1:0]     data_q,
    output logic [LANES-1:0]  mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mask_q <= '0;
        end else if (cap_en) begin
            addr_q <= addr_s;
            mask_q <= lanes_act;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        logic keep;
        if (i < LANES / 2) begin : g_low
            assign keep = 1'b1;
        end else begin : g_high
            assign keep = wide;
        end
        always_ff @(posedge clk) begin
            if (rst)         data_q[8*i +: 8] <= '0;
            else if (cap_en) data_q[8*i +: 8] <= keep ? data_s[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
    import hsp_pkg::*;
#(
    parameter int IDW = hsp_pkg::HSP_IDW,
    parameter int TW  = hsp_pkg::HSP_TW
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_act,
    input  logic        fall,
    input  logic        rise,
    input  logic        is_write,
    input  logic [IDW-1:0] id_s,
    input  logic [IDW-1:0] cfg_id,
    input  hsp_endcfg_t endcfg,
    output hsp_state_e  st,
    output logic        cap_en,
    output logic        ack_n,
    output logic        ack_oe,
    output logic        wr_valid
);
    logic          is_wr;
    logic          captured;
    logic [TW-1:0] cnt;

    assign cap_en = (st == ST_ACK) && !captured && !rise;
    assign ack_oe = (st == ST_ACK) || (st == ST_DRIVE);
    assign ack_n  = (st != ST_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            is_wr    <= 1'b0;
            captured <= 1'b0;
            cnt      <= '0;
            wr_valid <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cs_act && fall) begin
                        if (id_s == cfg_id) begin
                            st    <= ST_MATCH;
                            is_wr <= is_write;
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end
                end
                ST_MATCH, ST_SETUP: begin
                    captured <= 1'b0;
                    if (rise)         st <= ST_WAITCS;
                    else if (!cs_act) st <= ST_IDLE;
                    else              st <= (st == ST_MATCH) ? ST_SETUP : ST_ACK;
                end
                ST_ACK: begin
                    if (rise) begin
                        wr_valid <= is_wr && captured;
                        if (hsp_drive_after(endcfg)) begin
                            st  <= ST_DRIVE;
                            cnt <= endcfg.drv_time;
                        end else begin
                            st <= ST_WAITCS;
                        end
                    end else if (!cs_act) begin
                        st <= ST_IDLE;
                    end else begin
                        captured <= 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (cnt <= TW'(1)) st  <= ST_WAITCS;
                    else               cnt <= cnt - TW'(1);
                end
                ST_WAITCS, ST_IGNORE: begin
                    if (!cs_act) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsp_async_port.sv
module hsp_async_port
    import hsp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = hsp_pkg::HSP_LANES,
    parameter int IDW    = hsp_pkg::HSP_IDW,
    parameter int TW     = hsp_pkg::HSP_TW,
    localparam int DW    = LANES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDW-1:0]    cfg_chip_id,
    input  logic              cfg_drv_en,
    input  logic [TW-1:0]     cfg_drv_time,
    input  logic              cfg_single,
    input  logic              cfg_wide,
    input  logic              host_cs_n,
    input  logic [IDW-1:0]    host_id,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_data,
    input  logic [LANES-1:0]  host_bstb_n,
    input  logic              host_rstb_n,
    input  logic              host_rnw,
    output logic              host_ack_n,
    output logic              host_ack_oe,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [LANES-1:0]  wr_mask
);
    localparam int SW = 1 + IDW + ADDR_W + DW + LANES + 2;
    localparam logic [SW-1:0] SYNC_RST =
        {1'b1, {IDW{1'b0}}, {ADDR_W{1'b0}}, {DW{1'b0}}, {LANES{1'b1}}, 1'b1, 1'b1};

    logic              cs_n_s, rstb_n_s, rnw_s;
    logic [IDW-1:0]    id_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DW-1:0]     data_s;
    logic [LANES-1:0]  bstb_n_s;
    logic [LANES-1:0]  lanes_act;
    logic              is_write, fall, rise, cap_en;
    hsp_state_e        fsm_st;
    hsp_endcfg_t       endcfg;

    assign endcfg = '{drv_en: cfg_drv_en, drv_time: cfg_drv_time};

    hsp_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_cs_n, host_id, host_addr, host_data, host_bstb_n, host_rstb_n, host_rnw}),
        .q   ({cs_n_s, id_s, addr_s, data_s, bstb_n_s, rstb_n_s, rnw_s})
    );

    hsp_strobe_edge #(.LANES(LANES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .single    (cfg_single),
        .wide      (cfg_wide),
        .bstb_n_s  (bstb_n_s),
        .rstb_n_s  (rstb_n_s),
        .rnw_s     (rnw_s),
        .lanes_act (lanes_act),
        .is_write  (is_write),
        .fall      (fall),
        .rise      (rise)
    );

    hsp_ctrl #(.IDW(IDW), .TW(TW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (~cs_n_s),
        .fall     (fall),
        .rise     (rise),
        .is_write (is_write),
        .id_s     (id_s),
        .cfg_id   (cfg_chip_id),
        .endcfg   (endcfg),
        .st       (fsm_st),
        .cap_en   (cap_en),
        .ack_n    (host_ack_n),
        .ack_oe   (host_ack_oe),
        .wr_valid (wr_valid)
    );

    hsp_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .wide      (cfg_wide),
        .lanes_act (lanes_act),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .addr_q    (wr_addr),
        .data_q    (wr_data),
        .mask_q    (wr_mask)
    );
endmodule

// File: rtl/hsp_async_port_chk.sv
module hsp_async_port_chk
    import hsp_pkg::*;
#(
    parameter int LANES = hsp_pkg::HSP_LANES,
    parameter int TW    = hsp_pkg::HSP_TW
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wide,
    input logic             cfg_drv_en,
    input logic [TW-1:0]    cfg_drv_time,
    input logic             host_ack_n,
    input logic             host_ack_oe,
    input logic             wr_valid,
    input logic [LANES-1:0] wr_mask,
    input hsp_state_e       st
);
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!host_ack_oe && !wr_valid)); // R1

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> (!host_ack_oe && !wr_valid)); // R3

    AST_ACK_ORDER: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK) |-> ($past(st) == ST_SETUP || $past(st) == ST_ACK)); // R4

    AST_ACK_LOW_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !host_ack_n |-> host_ack_oe); // R4

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R6

    AST_WR_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(st) == ST_ACK)); // R6

    AST_HIGH_POLICY: assert property (@(posedge clk) disable iff (rst)
        (host_ack_oe && host_ack_n) |-> (cfg_drv_en && cfg_drv_time != '0)); // R7

    AST_NARROW_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !cfg_wide) |-> (wr_mask[LANES-1:LANES/2] == '0)); // R10
endmodule

bind hsp_async_port hsp_async_port_chk #(.LANES(LANES), .TW(TW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_wide     (cfg_wide),
    .cfg_drv_en   (cfg_drv_en),
    .cfg_drv_time (cfg_drv_time),
    .host_ack_n   (host_ack_n),
    .host_ack_oe  (host_ack_oe),
    .wr_valid     (wr_valid),
    .wr_mask      (wr_mask),
    .st           (fsm_st)
);

// File: tb/hsp_async_port_tb_top.sv
module hsp_async_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_chip_id = 4'hA;
    logic        cfg_drv_en = 1'b0;
    logic [1:0]  cfg_drv_time = 2'b00;
    logic        cfg_single = 1'b0;
    logic        cfg_wide = 1'b1;
    logic        host_cs_n = 1'b1;
    logic [3:0]  host_id = 4'h0;
    logic [15:0] host_addr = '0;
    logic [63:0] host_data = '0;
    logic [7:0]  host_bstb_n = 8'hFF;
    logic        host_rstb_n = 1'b1;
    logic        host_rnw = 1'b1;
    logic        host_ack_n, host_ack_oe, wr_valid;
    logic [15:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_mask;

    int tests = 0;
    int fails = 0;
    int wr_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsp_async_port dut_i (
        .clk(clk), .rst(rst), .cfg_chip_id(cfg_chip_id), .cfg_drv_en(cfg_drv_en),
        .cfg_drv_time(cfg_drv_time), .cfg_single(cfg_single), .cfg_wide(cfg_wide),
        .host_cs_n(host_cs_n), .host_id(host_id), .host_addr(host_addr),
        .host_data(host_data), .host_bstb_n(host_bstb_n), .host_rstb_n(host_rstb_n),
        .host_rnw(host_rnw), .host_ack_n(host_ack_n), .host_ack_oe(host_ack_oe),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    always @(posedge clk) if (!rst && wr_valid) wr_cnt <= wr_cnt + 1;

    function automatic logic [7:0] exp_mask(logic [7:0] act, bit wide);
        return wide ? act : (act & 8'h0F);
    endfunction

    function automatic logic [63:0] exp_data(logic [63:0] d, bit wide);
        return wide ? d : {32'h0, d[31:0]};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_access(bit wr, bit single, bit wide, bit match,
                              logic [7:0] act, logic [63:0] dat, logic [15:0] adr,
                              bit en, logic [1:0] t, bit cs_with_rise, bit abort);
        int  wc0;
        int  n;
        bit  exp_wr;
        bit  drv;
        @(negedge clk);
        cfg_single = single; cfg_wide = wide; cfg_drv_en = en; cfg_drv_time = t;
        host_id   = match ? cfg_chip_id : (cfg_chip_id ^ 4'(1 + $urandom_range(0, 14)));
        host_addr = adr; host_data = dat; host_rnw = !wr; host_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        wc0 = wr_cnt;
        if (wr || single) host_bstb_n = ~act;
        else              host_rstb_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(host_ack_oe == 1'b0, "R4 ack too early", 64'(host_ack_oe), 64'd0);
        @(negedge clk);
        check(host_ack_oe == match, "R3/R4 ack enable", 64'(host_ack_oe), 64'(match));
        if (match) check(host_ack_n == 1'b0, "R4 ack low", 64'(host_ack_n), 64'd0);
        // R2: identifier moves after the compare edge
        host_id = match ? ~cfg_chip_id : cfg_chip_id;
        repeat (3) @(negedge clk);
        exp_wr = match && wr;
        drv    = match && en && (t != 2'b00);
        if (abort) begin
            host_cs_n = 1'b1;
            repeat (3) @(negedge clk);
            check(host_ack_oe == 1'b0, "R11 abort drops ack", 64'(host_ack_oe), 64'd0);
            host_bstb_n = 8'hFF; host_rstb_n = 1'b1;
            repeat (5) @(negedge clk);
            check(wr_cnt == wc0, "R11 abort no write", 64'(wr_cnt - wc0), 64'd0);
            check(host_ack_oe == 1'b0, "R11 abort stays idle", 64'(host_ack_oe), 64'd0);
            return;
        end
        host_bstb_n = 8'hFF; host_rstb_n = 1'b1;
        if (cs_with_rise) host_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(wr_valid == exp_wr, wr ? "R6 write pulse" : "R9 read no write",
              64'(wr_valid), 64'(exp_wr));
        if (exp_wr) begin
            check(wr_mask == exp_mask(act, wide), "R5/R10 mask", 64'(wr_mask),
                  64'(exp_mask(act, wide)));
            check(wr_data == exp_data(dat, wide), "R5/R10 data", wr_data, exp_data(dat, wide));
            check(wr_addr == adr, "R5 addr", 64'(wr_addr), 64'(adr));
        end
        check(host_ack_oe == drv, drv ? "R7 drive on" : "R8 released",
              64'(host_ack_oe), 64'(drv));
        if (drv) begin
            check(host_ack_n == 1'b1, "R7 drive high", 64'(host_ack_n), 64'd1);
            n = 0;
            while (host_ack_oe && n < 10) begin
                n++;
                @(negedge clk);
            end
            check(n == int'(t), "R7 drive length", 64'(n), 64'(t));
        end
        host_cs_n = 1'b1;
        repeat (5) @(negedge clk);
        check(wr_cnt - wc0 == int'(exp_wr), "R6/R11 one write per access",
              64'(wr_cnt - wc0), 64'(exp_wr));
        check(host_ack_oe == 1'b0, "R11 idle after release", 64'(host_ack_oe), 64'd0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(host_ack_oe == 1'b0 && wr_valid == 1'b0, "R1 in reset",
              64'({host_ack_oe, wr_valid}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(host_ack_oe == 1'b0 && wr_valid == 1'b0, "R1 after reset",
              64'({host_ack_oe, wr_valid}), 64'd0);

        run_access(1, 0, 1, 1, 8'hA5, 64'h0123_4567_89AB_CDEF, 16'h1234, 1, 2'd3, 0, 0); // R5 R7
        run_access(1, 0, 1, 0, 8'hFF, 64'hDEAD_BEEF_0000_1111, 16'h0042, 1, 2'd2, 0, 0); // R2 R3
        run_access(0, 0, 1, 1, 8'h00, 64'h0, 16'h0007, 1, 2'd1, 0, 0);                 // R9 dual read
        run_access(1, 1, 0, 1, 8'hFF, 64'hFFEE_DDCC_BBAA_9988, 16'h2222, 1, 2'd0, 0, 0); // R8 R10
        run_access(0, 1, 1, 1, 8'h3C, 64'h5555_AAAA_5555_AAAA, 16'h3333, 0, 2'd2, 0, 0); // R8 R9
        run_access(1, 0, 1, 1, 8'h81, 64'h1357_9BDF_2468_ACE0, 16'h4444, 1, 2'd2, 1, 0); // R11 same cycle
        run_access(1, 0, 1, 1, 8'h0F, 64'hCAFE_F00D_CAFE_F00D, 16'h5555, 1, 2'd1, 0, 1); // R11 abort

        for (int k = 0; k < 30; k++) begin
            bit         wr   = $urandom_range(0, 3) != 0;
            bit         sgl  = $urandom_range(0, 1) == 1;
            bit         wide = $urandom_range(0, 1) == 1;
            bit         mt   = $urandom_range(0, 4) != 0;
            logic [7:0] act  = 8'($urandom);
            if ((act & 8'h0F) == 8'h00) act[0] = 1'b1;
            run_access(wr, sgl, wide, mt, act, {$urandom, $urandom}, 16'($urandom),
                       $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
                       $urandom_range(0, 3) == 0, 0);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule